// File: doc/BRIEF.md
# Shared Configuration Window with Commit Sequencer

This block gives software one shared set of configuration registers (the window) for a group of eight measurement channels. Software first writes the settings for one channel into the window: target channel, interval, calibration, decimation, averaging, input select, settle delay, two 16-bit thresholds and the enable byte. It then sets a handshake flag and asks for a commit. A small sequencer copies the whole window into the slot of the chosen channel and then clears the flag, which software polls to know that the window is free again.

The committed slots drive a flat configuration output for the conversion logic downstream. Each slot's enable bits also gate the per-channel low and high events that arrive from that logic. An event that passes its gate sets a bit in one of two pending bitmaps. Software clears these bitmaps by writing back a mask. The interrupt output is raised while any pending bit is set. The latest conversion code of each channel can be read little-endian from a bank of read-only registers.

All register access goes through a byte-wide port. Writes take effect at the clock edge. A read returns its data on `reg_rdata` one cycle after `reg_rd`, and `reg_rdata` holds that value until the next read.

Top module: `cfg_commit_engine`

## Requirements
- R1: The window bytes at 0x40-0x45 and 0x49-0x4d read back what was last written. At 0x46, only bit 7 (block enable) is kept and the other bits read as 0. Offsets 0x47 and 0x48 read as 0.
- R2: A write with bit 0 set to 0x0d sets the handshake flag. A write with bit 0 clear leaves the flag unchanged. A read of 0x0d returns the flag in bit 0.
- R3: A commit starts on a write with bit 7 set to 0x47 while the flag is set, the block is enabled and no commit is running. The flag is still set in the cycle after the request and reads as clear from the third cycle on.
- R4: A request made while the block enable (0x46 bit 7) is clear is ignored. The flag stays set and no slot changes.
- R5: A request made while the handshake flag is clear is ignored, and no slot changes.
- R6: A commit copies the whole window into the slot selected by 0x41 bits 7:5. Slice n of `slot_cfg` is 69 bits wide. From its MSB down it holds: the ID byte (0x40), the interval code (0x41[3:2]), calibration (0x42[5:4]), decimation (0x42[3:2]), fast-average enable (0x43[7]), sample count (0x43[6:0]), input select (0x44), settle (0x45[3:0]), low threshold ({0x4a,0x49}), high threshold ({0x4c,0x4b}), measure enable (0x4d[7]), high-interrupt enable (0x4d[1]) and low-interrupt enable (0x4d[0]). Other slots are unchanged.
- R7: A pulse on `evt_low[n]` (or `evt_high[n]`) sets pending bit n only when slot n has measure enable set together with its low (or high) interrupt enable.
- R8: The pending low bitmap reads at 0x0a and the pending high bitmap at 0x0c, with bit n for channel n. Writing a mask to either offset clears exactly the bits that are 1 in the mask. An event arriving in the same cycle as the clear wins.
- R9: `irq` is high exactly while any pending bit is set, and it changes in the same cycle as the bitmaps.
- R10: The code of channel n reads as its low byte at 0xa0+2n and its high byte at 0xa1+2n.
- R11: Committing a slot with 0x4d = 0 disables it. Later events on that channel set no pending bit.
- R12: A request made while a commit is still running is ignored. The target channel is the one selected when the running commit was accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 8 | Register offset |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, valid the cycle after reg_rd |
| evt_low | input | NCH | Per-channel low-threshold event pulses |
| evt_high | input | NCH | Per-channel high-threshold event pulses |
| result_code | input | NCH*16 | Latest conversion code, channel n at bits 16n+15:16n |
| slot_cfg | output | NCH*69 | Committed slot contents, channel n at bits 69n+68:69n |
| irq | output | 1 | OR of all pending status bits |

## Verification
The bench targets the two refusals of the commit sequencer: a request made without the flag, and a request made with the block disabled. A design that accepts either would enable a channel that software never committed, so later events would raise unexpected pending bits. It re-issues a request in the last cycle of a running commit while the channel select has just been changed. A sequencer that does not track its own busy state, or that reads the select late, writes the wrong slot. Partial-mask clears and long random mixes of gated events, clears and commits check that a clear removes only the masked bits and that disabled or half-enabled slots never let an event through.

// File: rtl/ccw_pkg.sv
package ccw_pkg;

  // Register offsets that software decodes.
  localparam logic [7:0] A_STAT_LO  = 8'h0A;
  localparam logic [7:0] A_STAT_HI  = 8'h0C;
  localparam logic [7:0] A_HSHAKE   = 8'h0D;
  localparam logic [7:0] A_WIN_BASE = 8'h40;
  localparam logic [7:0] A_COMMIT   = 8'h47;
  localparam logic [7:0] A_RES_BASE = 8'hA0;

  localparam int WIN_BYTES = 14;
  localparam int EN_IDX    = 6;   // window byte holding block enable
  localparam int REQ_IDX   = 7;   // commit request, not stored
  localparam int GAP_IDX   = 8;   // unused byte

  typedef struct packed {
    logic [7:0]  sid;
    logic [1:0]  interval;
    logic [1:0]  cal;
    logic [1:0]  decim;
    logic        avg_on;
    logic [6:0]  avg_cnt;
    logic [7:0]  inp;
    logic [3:0]  settle;
    logic [15:0] thr_lo;
    logic [15:0] thr_hi;
    logic        meas_on;
    logic        hi_ie;
    logic        lo_ie;
  } slot_t;

  localparam int SLOT_W = $bits(slot_t);

  typedef enum logic [1:0] {SQ_IDLE, SQ_COPY, SQ_DONE} seq_st_t;

  function automatic slot_t unpack_win(input logic [8*WIN_BYTES-1:0] w);
    slot_t s;
    s.sid      = w[7:0];
    s.interval = w[8+2 +: 2];
    s.cal      = w[16+4 +: 2];
    s.decim    = w[16+2 +: 2];
    s.avg_on   = w[24+7];
    s.avg_cnt  = w[24 +: 7];
    s.inp      = w[32 +: 8];
    s.settle   = w[40 +: 4];
    s.thr_lo   = w[72 +: 16];
    s.thr_hi   = w[88 +: 16];
    s.meas_on  = w[104+7];
    s.hi_ie    = w[104+1];
    s.lo_ie    = w[104];
    return s;
  endfunction

endpackage

// File: rtl/ccw_regwin.sv
module ccw_regwin
  import ccw_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   wr,
  input  logic [7:0]             addr,
  input  logic [7:0]             wdata,
  output logic [8*WIN_BYTES-1:0] win_flat,
  output logic                   blk_en
);

  for (genvar i = 0; i < WIN_BYTES; i++) begin : g_byte
    if (i == REQ_IDX || i == GAP_IDX) begin : g_none
      assign win_flat[8*i +: 8] = 8'h00;
    end else begin : g_reg
      logic [7:0] q;
      always_ff @(posedge clk) begin
        if (rst) begin
          q <= 8'h00;
        end else if (wr && addr == A_WIN_BASE + 8'(i)) begin
          if (i == EN_IDX) q <= {wdata[7], 7'b0};
          else             q <= wdata;
        end
      end
      assign win_flat[8*i +: 8] = q;
    end
  end

  assign blk_en = win_flat[8*EN_IDX + 7];

endmodule

// File: rtl/ccw_sequencer.sv
module ccw_sequencer
  import ccw_pkg::*;
#(
  parameter int NCH  = 8,
  parameter int CH_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hs_set,
  input  logic              req,
  input  logic              blk_en,
  input  logic [CH_W-1:0]   sel,
  input  slot_t             cfg_in,
  output logic              hs_flag,
  output logic              busy,
  output logic [NCH*SLOT_W-1:0] slot_cfg,
  output logic [NCH-1:0]    meas_on,
  output logic [NCH-1:0]    hi_ie,
  output logic [NCH-1:0]    lo_ie
);

  seq_st_t         st_q;
  logic [CH_W-1:0] tgt_q;
  slot_t           slots_q [NCH];

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= SQ_IDLE;
      tgt_q   <= '0;
      hs_flag <= 1'b0;
    end else begin
      case (st_q)
        SQ_IDLE: if (req && hs_flag && blk_en) begin
          tgt_q <= sel;
          st_q  <= SQ_COPY;
        end
        SQ_COPY: st_q <= SQ_DONE;
        SQ_DONE: begin
          hs_flag <= 1'b0;
          st_q    <= SQ_IDLE;
        end
        default: st_q <= SQ_IDLE;
      endcase
      if (hs_set) hs_flag <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int n = 0; n < NCH; n++) slots_q[n] <= '0;
    end else if (st_q == SQ_COPY) begin
      slots_q[tgt_q] <= cfg_in;
    end
  end

  assign busy = (st_q != SQ_IDLE);

  for (genvar n = 0; n < NCH; n++) begin : g_slot
    assign slot_cfg[n*SLOT_W +: SLOT_W] = slots_q[n];
    assign meas_on[n] = slots_q[n].meas_on;
    assign hi_ie[n]   = slots_q[n].hi_ie;
    assign lo_ie[n]   = slots_q[n].lo_ie;
  end

endmodule

// File: rtl/ccw_status.sv
module ccw_status #(
  parameter int NCH = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NCH-1:0] evt_lo,
  input  logic [NCH-1:0] evt_hi,
  input  logic [NCH-1:0] gate_lo,
  input  logic [NCH-1:0] gate_hi,
  input  logic           clr_lo,
  input  logic           clr_hi,
  input  logic [NCH-1:0] clr_mask,
  output logic [NCH-1:0] stat_lo,
  output logic [NCH-1:0] stat_hi,
  output logic           irq
);

  logic [NCH-1:0] nxt_lo, nxt_hi;

  always_comb begin
    nxt_lo = (stat_lo & ~(clr_lo ? clr_mask : '0)) | (evt_lo & gate_lo);
    nxt_hi = (stat_hi & ~(clr_hi ? clr_mask : '0)) | (evt_hi & gate_hi);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_lo <= '0;
      stat_hi <= '0;
      irq     <= 1'b0;
    end else begin
      stat_lo <= nxt_lo;
      stat_hi <= nxt_hi;
      irq     <= (|nxt_lo) | (|nxt_hi);
    end
  end

endmodule

// File: rtl/cfg_commit_engine.sv
module cfg_commit_engine
  import ccw_pkg::*;
#(
  parameter int NCH    = 8,
  parameter int CODE_W = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    reg_wr,
  input  logic                    reg_rd,
  input  logic [7:0]              reg_addr,
  input  logic [7:0]              reg_wdata,
  output logic [7:0]              reg_rdata,
  input  logic [NCH-1:0]          evt_low,
  input  logic [NCH-1:0]          evt_high,
  input  logic [NCH*CODE_W-1:0]   result_code,
  output logic [NCH*SLOT_W-1:0]   slot_cfg,
  output logic                    irq
);

  localparam int CH_W      = (NCH > 1) ? $clog2(NCH) : 1;
  localparam int RES_BYTES = CODE_W / 8;
  localparam int RES_SPAN  = NCH * RES_BYTES;

  logic [8*WIN_BYTES-1:0] win_flat;
  logic                   blk_en;
  logic                   hs_flag, seq_busy;
  logic [NCH-1:0]         meas_on, hi_ie, lo_ie, gate_lo, gate_hi;
  logic [NCH-1:0]         stat_lo, stat_hi;
  logic                   hs_set, req, clr_lo, clr_hi;
  logic [2:0]             sel3;
  slot_t                  cfg_in;
  logic [7:0]             rd_mux;

  assign hs_set = reg_wr && reg_addr == A_HSHAKE && reg_wdata[0];
  assign req    = reg_wr && reg_addr == A_COMMIT && reg_wdata[7];
  assign clr_lo = reg_wr && reg_addr == A_STAT_LO;
  assign clr_hi = reg_wr && reg_addr == A_STAT_HI;
  assign sel3   = win_flat[8+5 +: 3];
  assign cfg_in = unpack_win(win_flat);

  ccw_regwin u_win (
    .clk(clk), .rst(rst), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .win_flat(win_flat), .blk_en(blk_en)
  );

  ccw_sequencer #(.NCH(NCH), .CH_W(CH_W)) u_seq (
    .clk(clk), .rst(rst), .hs_set(hs_set), .req(req), .blk_en(blk_en),
    .sel(sel3[CH_W-1:0]), .cfg_in(cfg_in), .hs_flag(hs_flag), .busy(seq_busy),
    .slot_cfg(slot_cfg), .meas_on(meas_on), .hi_ie(hi_ie), .lo_ie(lo_ie)
  );

  assign gate_lo = meas_on & lo_ie;
  assign gate_hi = meas_on & hi_ie;

  ccw_status #(.NCH(NCH)) u_stat (
    .clk(clk), .rst(rst), .evt_lo(evt_low), .evt_hi(evt_high),
    .gate_lo(gate_lo), .gate_hi(gate_hi), .clr_lo(clr_lo), .clr_hi(clr_hi),
    .clr_mask(reg_wdata[NCH-1:0]), .stat_lo(stat_lo), .stat_hi(stat_hi), .irq(irq)
  );

  always_comb begin
    int widx, ridx;
    widx   = int'(reg_addr) - int'(A_WIN_BASE);
    ridx   = int'(reg_addr) - int'(A_RES_BASE);
    rd_mux = 8'h00;
    if (reg_addr == A_STAT_LO)      rd_mux = 8'(stat_lo);
    else if (reg_addr == A_STAT_HI) rd_mux = 8'(stat_hi);
    else if (reg_addr == A_HSHAKE)  rd_mux = {7'b0, hs_flag};
    else if (widx >= 0 && widx < WIN_BYTES)
      rd_mux = win_flat[widx*8 +: 8];
    else if (ridx >= 0 && ridx < RES_SPAN)
      rd_mux = result_code[(ridx / RES_BYTES) * CODE_W + (ridx % RES_BYTES) * 8 +: 8];
  end

  always_ff @(posedge clk) begin
    if (rst)         reg_rdata <= 8'h00;
    else if (reg_rd) reg_rdata <= rd_mux;
  end

endmodule

// File: rtl/ccw_checks.sv
module ccw_checks #(
  parameter int NCH = 8
) (
  input logic           clk,
  input logic           rst,
  input logic           reg_wr,
  input logic [7:0]     reg_addr,
  input logic [7:0]     reg_wdata,
  input logic [NCH-1:0] evt_low,
  input logic           hs_flag,
  input logic           seq_busy,
  input logic           blk_en,
  input logic [NCH-1:0] stat_lo,
  input logic [NCH-1:0] stat_hi,
  input logic [NCH-1:0] gate_lo,
  input logic [NCH-1:0] gate_hi,
  input logic           irq
);

  AST_IRQ_TRACKS_STATUS: assert property (@(posedge clk) disable iff (rst)
    irq == ((|stat_lo) || (|stat_hi))); // R9

  AST_COMMIT_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (rst)
    $rose(seq_busy) |-> ($past(hs_flag) && $past(blk_en))); // R4

  AST_FLAG_CLEARED_AFTER_COMMIT: assert property (@(posedge clk) disable iff (rst)
    ($fell(seq_busy) && !$past(reg_wr && reg_addr == 8'h0D && reg_wdata[0])) |-> !hs_flag); // R3

  AST_NO_UNGATED_LOW: assert property (@(posedge clk) disable iff (rst)
    (stat_lo & ~$past(stat_lo) & ~$past(gate_lo)) == '0); // R7

  AST_NO_UNGATED_HIGH: assert property (@(posedge clk) disable iff (rst)
    (stat_hi & ~$past(stat_hi) & ~$past(gate_hi)) == '0); // R7

  AST_LOW_CLEAR_MASK: assert property (@(posedge clk) disable iff (rst)
    $past(reg_wr && reg_addr == 8'h0A) |->
      ((stat_lo & $past(reg_wdata[NCH-1:0]) & ~$past(evt_low)) == '0)); // R8

endmodule

bind cfg_commit_engine ccw_checks #(.NCH(NCH)) u_chk (
  .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
  .evt_low(evt_low), .hs_flag(hs_flag), .seq_busy(seq_busy), .blk_en(blk_en),
  .stat_lo(stat_lo), .stat_hi(stat_hi), .gate_lo(gate_lo), .gate_hi(gate_hi), .irq(irq)
);

// File: tb/cfg_commit_engine_test.sv
`timescale 1ns/1ps
module cfg_commit_engine_test;
  localparam int NCH = 8;
  localparam int SW  = 69;

  logic clk = 1'b0, rst = 1'b1;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0] reg_addr = 8'h00, reg_wdata = 8'h00, reg_rdata;
  logic [NCH-1:0] evt_low = '0, evt_high = '0;
  logic [NCH*16-1:0] result_code = '0;
  logic [NCH*SW-1:0] slot_cfg;
  logic irq;

  int n_chk = 0, n_bad = 0;
  logic [7:0] wb [14];
  logic [NCH-1:0] m_meas = '0, m_hie = '0, m_lie = '0, m_lo = '0, m_hi = '0;

  always #4 clk = ~clk;

  cfg_commit_engine uut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_low(evt_low), .evt_high(evt_high),
    .result_code(result_code), .slot_cfg(slot_cfg), .irq(irq)
  );

  task automatic chk(input string req, input logic [127:0] got, input logic [127:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    if (a >= 8'h40 && a <= 8'h4d) wb[a - 8'h40] = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] v);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    v = reg_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [SW-1:0] exp_slot();
    return {wb[0], wb[1][3:2], wb[2][5:4], wb[2][3:2], wb[3][7], wb[3][6:0], wb[4],
            wb[5][3:0], wb[10], wb[9], wb[12], wb[11], wb[13][7], wb[13][1], wb[13][0]};
  endfunction

  task automatic model_commit(input int ch);
    m_meas[ch] = wb[13][7]; m_hie[ch] = wb[13][1]; m_lie[ch] = wb[13][0];
  endtask

  task automatic commit(input int ch, input logic [7:0] meas);
    wr(8'h41, {3'(ch), wb[1][4:0]});
    wr(8'h4d, meas);
    wr(8'h46, 8'h80);
    wr(8'h0d, 8'h01);
    wr(8'h47, 8'h80);
    idle(3);
    model_commit(ch);
  endtask

  task automatic evt(input logic [NCH-1:0] lo, input logic [NCH-1:0] hi);
    evt_low = lo; evt_high = hi;
    @(negedge clk);
    evt_low = '0; evt_high = '0;
    m_lo |= lo & m_meas & m_lie;
    m_hi |= hi & m_meas & m_hie;
  endtask

  task automatic check_status(input string req);
    logic [7:0] v;
    rd(8'h0a, v); chk(req, v, 8'(m_lo));
    rd(8'h0c, v); chk(req, v, 8'(m_hi));
    chk("R9", irq, (|m_lo) | (|m_hi));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] v;
    void'($urandom(32'd1234));
    for (int i = 0; i < 14; i++) wb[i] = 8'h00;
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // reset state
    rd(8'h0d, v); chk("R2 reset", v, 8'h00);
    check_status("R8 reset");

    // R1 window readback
    for (int i = 0; i < 14; i++) if (i != 7 && i != 8) wr(8'h40 + 8'(i), 8'($urandom));
    wr(8'h46, 8'hff); wb[6] = 8'h80;
    for (int i = 0; i < 14; i++) begin
      rd(8'h40 + 8'(i), v);
      chk("R1", v, (i == 7 || i == 8) ? 8'h00 : wb[i]);
    end

    // R10 result bank
    for (int n = 0; n < NCH; n++) result_code[n*16 +: 16] = 16'($urandom);
    for (int n = 0; n < NCH; n++) begin
      rd(8'ha0 + 8'(2*n), v); chk("R10 lo", v, result_code[n*16 +: 8]);
      rd(8'ha1 + 8'(2*n), v); chk("R10 hi", v, result_code[n*16+8 +: 8]);
    end

    // R2 write of zero leaves flag clear
    wr(8'h0d, 8'hfe); rd(8'h0d, v); chk("R2 zero", v, 8'h00);

    // R5 request without flag
    wr(8'h41, 8'h40); wr(8'h4d, 8'h83); wr(8'h46, 8'h80);
    wr(8'h47, 8'h80); idle(3);
    chk("R5", slot_cfg[2*SW +: SW], '0);
    evt(8'h04, 8'h04); check_status("R5");

    // R4 request with block disabled
    wr(8'h46, 8'h00); wr(8'h0d, 8'h01);
    rd(8'h0d, v); chk("R2 set", v, 8'h01);
    wr(8'h47, 8'h80); idle(3);
    rd(8'h0d, v); chk("R4 flag", v, 8'h01);
    chk("R4 slot", slot_cfg[2*SW +: SW], '0);

    // R3 commit and handshake timing
    wr(8'h46, 8'h80);
    wr(8'h47, 8'h80);
    rd(8'h0d, v); chk("R3 busy", v, 8'h01);
    idle(3);
    rd(8'h0d, v); chk("R3 done", v, 8'h00);
    model_commit(2);
    chk("R6 copy", slot_cfg[2*SW +: SW], exp_slot());
    chk("R6 other", slot_cfg[0 +: SW], '0);
    evt(8'hff, 8'h00); check_status("R7 low");
    evt(8'h00, 8'hff); check_status("R7 high");

    // R12 re-request during running commit, select changed meanwhile
    wr(8'h41, 8'h60); wr(8'h4d, 8'h81); wr(8'h0d, 8'h01);
    wr(8'h47, 8'h80);
    wr(8'h41, 8'ha0);
    wr(8'h47, 8'h80);
    idle(3);
    m_meas[3] = 1'b1; m_lie[3] = 1'b1; m_hie[3] = 1'b0;
    chk("R12 slot5", slot_cfg[5*SW +: SW], '0);
    evt(8'hff, 8'hff); check_status("R12");

    // R8 partial clears
    wr(8'h0a, 8'h04); m_lo &= ~8'h04; check_status("R8 lo");
    wr(8'h0c, 8'hff); m_hi = '0; check_status("R8 hi");

    // R8 event in same cycle as clear wins
    evt_low = 8'h08; wr(8'h0a, 8'h08); evt_low = '0;
    check_status("R8 race");

    // R11 disable channel 3 and clear
    commit(3, 8'h00);
    wr(8'h0a, 8'hff); m_lo = '0;
    evt(8'h08, 8'h08); check_status("R11");

    // random mix
    for (int it = 0; it < 400; it++) begin
      int op = $urandom_range(0, 9);
      if (op < 5) evt(8'($urandom), 8'($urandom));
      else if (op < 7) begin
        logic [7:0] mk = 8'($urandom);
        if (op == 5) begin wr(8'h0a, mk); m_lo &= ~mk; end
        else begin wr(8'h0c, mk); m_hi &= ~mk; end
      end else begin
        int ch = $urandom_range(0, NCH-1);
        logic [7:0] ms = 8'($urandom) & 8'h83;
        commit(ch, ms);
        chk("R6 rand", slot_cfg[ch*SW +: SW], exp_slot());
      end
      check_status("R7 rand");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule